// File: doc/BRIEF.md
# Asynchronous NAND Bus Strobe Sequencer

This block turns a simple host request (an address, a write flag, a word or byte size flag and 32 bits of write data) into byte cycles on an 8-bit asynchronous NAND bus. It drives an active-low chip enable, an active-low write enable and an active-low read enable. It also drives the address-latch and command-latch enables, an output data byte with its drive enable, and it samples the input data byte. The length of every bus phase comes from one packed 32-bit timing word. That word gives the write and read sides their own setup, strobe and hold counts, sets a direction-change gap, and selects a mode in which chip enable itself acts as the strobe.

The host starts an access by raising a request while the block is not busy. A word access becomes four byte cycles at the same NAND address, least-significant byte first. A byte access uses lane 0 only. The address-latch and command-latch enables come from fixed bits of the host byte address. When an access finishes, a one-cycle done pulse marks the end, and for a read the gathered bytes are then valid on the read data port. The shared wire-AND ready/busy line of the flash devices is brought into the clock domain and shown as a ready status bit.

Top module: `nand_seq_top`

## Requirements
- R1: A synchronous reset, applied at any time, deasserts all strobes on the next cycle: chip, write and read enables go high, the address and command latch enables and the data drive enable go low, and busy and done go low. The first access after reset never gets a turnaround gap.
- R2: Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4]. Each phase lasts its field value plus one cycle, so one byte takes setup+strobe+hold+3 cycles.
- R3: Write enable is low only in the strobe phase of a write byte, and read enable only in the strobe phase of a read byte. Each stays low for exactly strobe+1 cycles per byte. The two are never low together, and the data drive enable is high whenever write enable is low.
- R4: With timing word bit 31 clear, chip enable is low through the setup, strobe and hold phases of every byte, and high at all other times.
- R5: With timing word bit 31 set, chip enable is low only during strobe phases.
- R6: Timing word bits [3:2] give the turnaround count. When an access runs in the opposite direction to the last completed access, turnaround+1 cycles with chip enable high come before its first setup phase. No gap is inserted between accesses in the same direction.
- R7: The command latch enable follows host address bit 4. The address latch enable follows host address bit 3 only when bit 4 is clear, so the command latch wins when both are set. Both are held during the bus phases of the access and are low otherwise. Address bits [1:0] have no effect.
- R8: A word access (word flag 1) performs four byte cycles that drive write data bits [7:0], then [15:8], then [23:16], then [31:24]. A byte access performs one cycle on bits [7:0].
- R9: A read byte is captured from the NAND input on the last cycle of its strobe phase and placed in the read data lane of its position. Lanes not read are zero.
- R10: A request is accepted only in a cycle where busy is low, including the cycle of a done pulse. A request made while busy is ignored. Done is high for exactly one cycle, right after the last hold phase, and busy is low in that cycle.
- R11: The ready status output equals the ready/busy input delayed by two clock cycles.
- R12: Timing word bits 30 and 0 have no effect on the bus cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostReq | input | 1 | Start an access (taken when busy is low) |
| hostWrite | input | 1 | 1 = write access, 0 = read access |
| hostWord | input | 1 | 1 = four byte cycles, 0 = one byte cycle |
| hostAddr | input | ADDR_W (16) | Host byte address; bits 4 and 3 select command/address latch |
| hostWdata | input | DATA_W (32) | Write data, lane 0 sent first |
| timingCfg | input | 32 | Packed phase timing word, sampled when an access is accepted |
| hostBusy | output | 1 | Access in progress |
| hostDone | output | 1 | One-cycle pulse at the end of an access |
| hostRdata | output | DATA_W (32) | Bytes gathered by the last read |
| hostRdy | output | 1 | Synchronised ready/busy status |
| nandCeN | output | 1 | Chip enable, active low |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandAle | output | 1 | Address latch enable |
| nandCle | output | 1 | Command latch enable |
| nandDout | output | 8 | Data byte driven toward the flash |
| nandDoe | output | 1 | Drive enable for nandDout |
| nandDin | input | 8 | Data byte from the flash |
| nandRdy | input | 1 | Wire-AND ready/busy line from the flash devices |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same cycle. So can the direction check that decides whether a turnaround gap is needed. The bench issues every table vector in the cycle that done is seen, so each back-to-back access is accepted during the done pulse. It judges the result by the busy-cycle count: a direction flip must add exactly turnaround+1 cycles, and a same-direction access must add none. A second collision comes from a reset during an access in progress. The access right after it must show no turnaround, even though its direction differs from the access that was cut off.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int CFG_W   = 32;
  localparam int CNT_W   = 6;
  localparam int BYTE_W  = 8;

  // Field positions of the packed timing word (decoded by the sequencer)
  localparam int WR_SETUP_LSB  = 26;
  localparam int WR_STROBE_LSB = 20;
  localparam int WR_HOLD_LSB   = 17;
  localparam int RD_SETUP_LSB  = 13;
  localparam int RD_STROBE_LSB = 7;
  localparam int RD_HOLD_LSB   = 4;
  localparam int TURN_LSB      = 2;
  localparam int SEL_STROBE_BIT = 31;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } dirTiming_t;

  typedef struct packed {
    dirTiming_t       wr;
    dirTiming_t       rd;
    logic [CNT_W-1:0] turn;
    logic             selStrobe;
  } timing_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic busPhase;     // setup, strobe or hold of a byte
    logic strobeOn;     // strobe phase
    logic isWrite;      // direction of the access in progress
    logic selStrobe;    // chip enable acts as strobe
    logic captureByte;  // last read strobe cycle
    logic latchReq;     // request accepted this cycle
  } ctrlStrobes_t;

  function automatic timing_t decodeTiming(input logic [CFG_W-1:0] w);
    timing_t t;
    t.wr.setup  = CNT_W'(w[WR_SETUP_LSB  +: 4]);
    t.wr.strobe = CNT_W'(w[WR_STROBE_LSB +: 6]);
    t.wr.hold   = CNT_W'(w[WR_HOLD_LSB   +: 3]);
    t.rd.setup  = CNT_W'(w[RD_SETUP_LSB  +: 4]);
    t.rd.strobe = CNT_W'(w[RD_STROBE_LSB +: 6]);
    t.rd.hold   = CNT_W'(w[RD_HOLD_LSB   +: 3]);
    t.turn      = CNT_W'(w[TURN_LSB      +: 2]);
    t.selStrobe = w[SEL_STROBE_BIT];
    return t;
  endfunction

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostWord,
  input  logic [CFG_W-1:0]  cfgWord,
  output ctrlStrobes_t      ctl,
  output logic [LANE_W-1:0] lane,
  output logic              busy,
  output logic              done
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [LANE_W-1:0] laneR;
  logic [LANE_W-1:0] lastLane;
  logic             isWr;
  logic             prevValid;
  logic             prevWr;
  logic             doneR;
  timing_t          tim;

  timing_t    decNow;
  dirTiming_t dirNow;
  dirTiming_t dirCur;
  logic       cntZero;
  logic       accept;
  logic       needTurn;

  always_comb begin
    decNow   = decodeTiming(cfgWord);
    dirNow   = hostWrite ? decNow.wr : decNow.rd;
    dirCur   = isWr ? tim.wr : tim.rd;
    cntZero  = (cnt == '0);
    accept   = (phase == PH_IDLE) && hostReq;
    needTurn = prevValid && (prevWr != hostWrite);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      laneR     <= '0;
      lastLane  <= '0;
      isWr      <= 1'b0;
      prevValid <= 1'b0;
      prevWr    <= 1'b0;
      doneR     <= 1'b0;
      tim       <= '0;
    end else begin
      doneR <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            tim      <= decNow;
            isWr     <= hostWrite;
            laneR    <= '0;
            lastLane <= hostWord ? LAST_LANE : '0;
            if (needTurn) begin
              phase <= PH_TURN;
              cnt   <= decNow.turn;
            end else begin
              phase <= PH_SETUP;
              cnt   <= dirNow.setup;
            end
          end
        end
        PH_TURN: begin
          if (cntZero) begin
            phase <= PH_SETUP;
            cnt   <= dirCur.setup;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase <= PH_STROBE;
            cnt   <= dirCur.strobe;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cntZero) begin
            phase <= PH_HOLD;
            cnt   <= dirCur.hold;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (laneR == lastLane) begin
            phase     <= PH_IDLE;
            doneR     <= 1'b1;
            prevValid <= 1'b1;
            prevWr    <= isWr;
          end else begin
            phase <= PH_SETUP;
            cnt   <= dirCur.setup;
            laneR <= laneR + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.busPhase    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctl.strobeOn    = (phase == PH_STROBE);
    ctl.isWrite     = isWr;
    ctl.selStrobe   = tim.selStrobe;
    ctl.captureByte = (phase == PH_STROBE) && cntZero && !isWr;
    ctl.latchReq    = accept;
  end

  assign lane = laneR;
  assign busy = (phase != PH_IDLE);
  assign done = doneR;

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LANES       = DATA_W / BYTE_W,
  parameter int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      ctl,
  input  logic [LANE_W-1:0] lane,
  input  logic              addrAleBit,
  input  logic              addrCleBit,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [BYTE_W-1:0] nandDin,
  input  logic              nandRdy,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRdy,
  output logic              nandCeN,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandAle,
  output logic              nandCle,
  output logic [BYTE_W-1:0] nandDout,
  output logic              nandDoe
);

  logic              aleR;
  logic              cleR;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] rdataR;
  logic [BYTE_W-1:0] laneByte [LANES];
  logic [SYNC_STAGES-1:0] rdySync;

  always_ff @(posedge clk) begin
    if (rst) begin
      aleR   <= 1'b0;
      cleR   <= 1'b0;
      wdataR <= '0;
      rdataR <= '0;
    end else begin
      if (ctl.latchReq) begin
        cleR   <= addrCleBit;
        aleR   <= addrAleBit && !addrCleBit;
        wdataR <= hostWdata;
        rdataR <= '0;
      end else if (ctl.captureByte) begin
        rdataR[lane*BYTE_W +: BYTE_W] <= nandDin;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneByte[g] = wdataR[g*BYTE_W +: BYTE_W];
  end

  if (SYNC_STAGES == 1) begin : gSync1
    always_ff @(posedge clk) begin
      if (rst) rdySync <= '0;
      else     rdySync <= nandRdy;
    end
  end else begin : gSyncN
    always_ff @(posedge clk) begin
      if (rst) rdySync <= '0;
      else     rdySync <= {rdySync[SYNC_STAGES-2:0], nandRdy};
    end
  end

  always_comb begin
    nandCeN  = !(ctl.busPhase && (!ctl.selStrobe || ctl.strobeOn));
    nandWeN  = !(ctl.strobeOn && ctl.isWrite);
    nandReN  = !(ctl.strobeOn && !ctl.isWrite);
    nandAle  = ctl.busPhase && aleR;
    nandCle  = ctl.busPhase && cleR;
    nandDoe  = ctl.busPhase && ctl.isWrite;
    nandDout = laneByte[lane];
  end

  assign hostRdata = rdataR;
  assign hostRdy   = rdySync[SYNC_STAGES-1];

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int ALE_BIT     = 3,
  parameter int CLE_BIT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostWord,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [CFG_W-1:0]  timingCfg,
  output logic              hostBusy,
  output logic              hostDone,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRdy,
  output logic              nandCeN,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandAle,
  output logic              nandCle,
  output logic [BYTE_W-1:0] nandDout,
  output logic              nandDoe,
  input  logic [BYTE_W-1:0] nandDin,
  input  logic              nandRdy
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  ctrlStrobes_t      ctl;
  logic [LANE_W-1:0] lane;

  nand_seq_ctrl #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostWord (hostWord),
    .cfgWord  (timingCfg),
    .ctl      (ctl),
    .lane     (lane),
    .busy     (hostBusy),
    .done     (hostDone)
  );

  nand_seq_dp #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .LANES      (LANES),
    .LANE_W     (LANE_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .lane      (lane),
    .addrAleBit(hostAddr[ALE_BIT]),
    .addrCleBit(hostAddr[CLE_BIT]),
    .hostWdata (hostWdata),
    .nandDin   (nandDin),
    .nandRdy   (nandRdy),
    .hostRdata (hostRdata),
    .hostRdy   (hostRdy),
    .nandCeN   (nandCeN),
    .nandWeN   (nandWeN),
    .nandReN   (nandReN),
    .nandAle   (nandAle),
    .nandCle   (nandCle),
    .nandDout  (nandDout),
    .nandDoe   (nandDoe)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst,
  input logic hostReq,
  input logic hostBusy,
  input logic hostDone,
  input logic nandCeN,
  input logic nandWeN,
  input logic nandReN,
  input logic nandAle,
  input logic nandCle,
  input logic nandDoe
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!nandWeN && !nandReN)); // R3

  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !nandWeN |-> nandDoe); // R3

  AST_STROBE_CE: assert property (@(posedge clk) disable iff (rst)
    (!nandWeN || !nandReN) |-> !nandCeN); // R4

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(nandAle && nandCle)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hostBusy |-> (nandCeN && nandWeN && nandReN && !nandAle && !nandCle)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    hostDone |=> !hostDone); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    hostDone |-> ($past(hostBusy) && !hostBusy)); // R10

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(hostBusy) |-> $past(hostReq)); // R10

endmodule

bind nand_seq_top nand_seq_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .hostReq (hostReq),
  .hostBusy(hostBusy),
  .hostDone(hostDone),
  .nandCeN (nandCeN),
  .nandWeN (nandWeN),
  .nandReN (nandReN),
  .nandAle (nandAle),
  .nandCle (nandCle),
  .nandDoe (nandDoe)
);

// File: tb/nand_seq_tb.sv
module nand_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic        hostWord = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] timingCfg = '0;
  logic        hostBusy, hostDone, hostRdy;
  logic [31:0] hostRdata;
  logic        nandCeN, nandWeN, nandReN, nandAle, nandCle, nandDoe;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin;
  logic        nandRdy = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rdIdx  = 0;

  always #2 clk = ~clk;

  nand_seq_top dut_i (
    .clk(clk), .rst(rst), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostWord(hostWord), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .timingCfg(timingCfg), .hostBusy(hostBusy), .hostDone(hostDone),
    .hostRdata(hostRdata), .hostRdy(hostRdy), .nandCeN(nandCeN),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandAle(nandAle),
    .nandCle(nandCle), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRdy(nandRdy)
  );

  function automatic logic [7:0] patByte(input int i);
    return 8'h5A ^ 8'(i * 29);
  endfunction

  assign nandDin = patByte(rdIdx);

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] addr;
    logic        wr;
    logic        word;
    logic [31:0] wdata;
    logic [7:0]  expBusy;
    logic [7:0]  expCe;
    logic [7:0]  expStb;
    logic        expAle;
    logic        expCle;
  } vec_t;

  localparam logic [31:0] CFG_A = 32'h0432_018C; // w 1/3/1, r 0/3/0, turn 3
  localparam logic [31:0] CFG_B = 32'h0000_0000;
  localparam logic [31:0] CFG_C = 32'h8432_018C; // CFG_A with chip enable as strobe
  localparam logic [31:0] CFG_D = 32'h3FFF_FFFC; // every count at maximum
  localparam logic [31:0] CFG_E = 32'h4000_0001; // only ignored bits set (R12)

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{CFG_A, 16'h0010, 1'b1, 1'b1, 32'h1122_3344, 8'd32, 8'd32, 8'd16, 1'b0, 1'b1},
    '{CFG_A, 16'h0008, 1'b1, 1'b0, 32'h0000_00A5, 8'd8,  8'd8,  8'd4,  1'b1, 1'b0},
    '{CFG_A, 16'h0000, 1'b0, 1'b1, 32'h0,         8'd28, 8'd24, 8'd16, 1'b0, 1'b0},
    '{CFG_A, 16'h0003, 1'b0, 1'b0, 32'h0,         8'd6,  8'd6,  8'd4,  1'b0, 1'b0},
    '{CFG_B, 16'h0018, 1'b1, 1'b1, 32'hDEAD_BEEF, 8'd13, 8'd12, 8'd4,  1'b0, 1'b1},
    '{CFG_B, 16'h0004, 1'b0, 1'b1, 32'h0,         8'd13, 8'd12, 8'd4,  1'b0, 1'b0},
    '{CFG_C, 16'h0008, 1'b1, 1'b1, 32'hC0FF_EE01, 8'd36, 8'd16, 8'd16, 1'b1, 1'b0},
    '{CFG_C, 16'h0000, 1'b0, 1'b0, 32'h0,         8'd10, 8'd4,  8'd4,  1'b0, 1'b0},
    '{CFG_D, 16'h0010, 1'b1, 1'b0, 32'h0000_0077, 8'd92, 8'd88, 8'd64, 1'b0, 1'b1},
    '{CFG_D, 16'h0008, 1'b0, 1'b0, 32'h0,         8'd92, 8'd88, 8'd64, 1'b1, 1'b0},
    '{CFG_E, 16'h0000, 1'b1, 1'b0, 32'h0000_0042, 8'd4,  8'd3,  8'd1,  1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  int lastStb = 0;
  int lastWrites = 0;
  int lastReLow = 0;

  // Entered at a negedge; drives the request there, returns at the done negedge.
  task automatic runVec(input vec_t v, input string busyTag);
    int busyCnt = 0;
    int ceCnt = 0;
    int stbCnt = 0;
    int reLow = 0;
    int nWr = 0;
    int guard = 0;
    int rdStart;
    int nBytes;
    bit aleSeen = 0;
    bit cleSeen = 0;
    bit prevStb = 0;
    bit stb;
    logic [7:0] wrBytes [4];
    logic [31:0] expRd;
    nBytes = v.word ? 4 : 1;
    rdStart = rdIdx;
    for (int k = 0; k < 4; k++) wrBytes[k] = 8'h00;
    hostReq = 1'b1; hostWrite = v.wr; hostWord = v.word;
    hostAddr = v.addr; hostWdata = v.wdata; timingCfg = v.cfg;
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostDone && guard < 1000) begin
      if (hostBusy) busyCnt++;
      if (!nandCeN) ceCnt++;
      if (nandAle) aleSeen = 1;
      if (nandCle) cleSeen = 1;
      if (!nandReN) reLow++;
      stb = !nandWeN || !nandReN;
      if (stb) stbCnt++;
      if (!nandWeN && !prevStb && nWr < 4) begin
        wrBytes[nWr] = nandDout;
        nWr++;
      end
      if (!stb && prevStb && !v.wr) rdIdx++;
      prevStb = stb;
      @(negedge clk);
      guard++;
    end
    lastStb = stbCnt; lastWrites = nWr; lastReLow = reLow;
    check(busyCnt == int'(v.expBusy), busyTag, busyCnt, int'(v.expBusy));
    check(ceCnt == int'(v.expCe), "R4 R5 chip enable low cycles", ceCnt, int'(v.expCe));
    check(stbCnt == int'(v.expStb), "R3 strobe low cycles", stbCnt, int'(v.expStb));
    check(aleSeen == v.expAle, "R7 address latch", int'(aleSeen), int'(v.expAle));
    check(cleSeen == v.expCle, "R7 command latch", int'(cleSeen), int'(v.expCle));
    check(!hostBusy, "R10 busy low with done", int'(hostBusy), 0);
    if (v.wr) begin
      check(nWr == nBytes, "R8 byte count", nWr, nBytes);
      for (int k = 0; k < nBytes; k++)
        check(wrBytes[k] == v.wdata[k*8 +: 8], "R8 write byte order", int'(wrBytes[k]),
              int'(v.wdata[k*8 +: 8]));
    end else begin
      expRd = '0;
      for (int k = 0; k < nBytes; k++) expRd[k*8 +: 8] = patByte(rdStart + k);
      check(hostRdata == expRd, "R9 read data", int'(hostRdata), int'(expRd));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    vec_t dv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(nandCeN && nandWeN && nandReN, "R1 strobes high after reset",
          int'({nandCeN, nandWeN, nandReN}), 7);
    check(!nandAle && !nandCle && !nandDoe, "R1 latches and drive low",
          int'({nandAle, nandCle, nandDoe}), 0);
    check(!hostBusy && !hostDone, "R1 busy and done low", int'({hostBusy, hostDone}), 0);

    // R11: ready status follows the input two cycles later
    nandRdy = 1'b1;
    @(negedge clk);
    check(hostRdy == 1'b0, "R11 ready after one cycle", int'(hostRdy), 0);
    @(negedge clk);
    check(hostRdy == 1'b1, "R11 ready after two cycles", int'(hostRdy), 1);
    nandRdy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(hostRdy == 1'b0, "R11 busy after two cycles", int'(hostRdy), 0);

    // Table walk: each vector is issued in the done cycle of the previous one
    for (int i = 0; i < NVEC; i++)
      runVec(VECS[i], (i == NVEC - 1) ? "R12 ignored bits, cycle count" : "R2 R6 busy cycles");

    // R10: done is a single pulse and a request during busy is ignored
    dv = '{CFG_A, 16'h0000, 1'b1, 1'b0, 32'h0000_0033, 8'd8, 8'd8, 8'd4, 1'b0, 1'b0};
    fork
      runVec(dv, "R10 busy cycles with stray request");
      begin
        @(negedge clk); @(negedge clk);
        hostReq = 1'b1; hostWrite = 1'b0; hostWord = 1'b1;
        repeat (3) @(negedge clk);
        hostReq = 1'b0;
      end
    join
    check(lastReLow == 0, "R10 stray request produced no read", lastReLow, 0);
    @(negedge clk);
    check(!hostDone, "R10 done lasts one cycle", int'(hostDone), 0);
    check(!hostBusy, "R10 no access after ignored request", int'(hostBusy), 0);

    // R1: reset during an access, then no turnaround on the next access
    hostReq = 1'b1; hostWrite = 1'b1; hostWord = 1'b1;
    hostAddr = 16'h0010; hostWdata = 32'h0102_0304; timingCfg = CFG_D;
    @(negedge clk);
    hostReq = 1'b0;
    repeat (20) @(negedge clk);
    check(!nandCeN, "R4 chip enable low mid-access", int'(nandCeN), 0);
    rst = 1'b1;
    @(negedge clk);
    check(nandCeN && nandWeN && nandReN && !nandCle, "R1 strobes idle after reset",
          int'({nandCeN, nandWeN, nandReN, nandCle}), 14);
    check(!hostBusy, "R1 busy cleared by reset", int'(hostBusy), 0);
    rst = 1'b0;
    @(negedge clk);
    dv = '{CFG_B, 16'h0001, 1'b0, 1'b0, 32'h0, 8'd3, 8'd3, 8'd1, 1'b0, 1'b0};
    runVec(dv, "R1 R6 no turnaround after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule